// File: doc/BRIEF.md
# Audio Subsystem Interval Timers

This block holds three programmable interval timers for a sound coprocessor that runs from a 1.024 MHz clock. Each timer divides the clock by a fixed prescale factor: 128 for timers 0 and 1, which gives 8 kHz steps, and 16 for timer 2, which gives 64 kHz steps. The prescaled steps drive an internal stage count. When the stage count reaches the timer's 8-bit period, it returns to zero and a small 4-bit output counter advances.

The processor polls each output counter with a read strobe. A read returns the count and empties the counter in the same access. A separate clear strobe empties a counter without reading it. Each timer has a level enable. When the enable rises, the timer restarts from nothing: the prescaler, the stage count and the output counter all go to zero. Bus decoding is done outside this block, which sees only per-timer strobes and a shared period data byte.

Top module: `aud_interval_timers`

## Requirements
- R1: While a timer is enabled, its stage count advances once every 128 clocks for timers 0 and 1, and once every 16 clocks for timer 2. The first step comes that many clocks after the edge on which the enable was seen rising.
- R2: When a step would bring the stage count to the timer's period, the stage count returns to 0 and the output counter increases by one. With period P and prescale D, the first increment lands P×D clock edges after the enable edge.
- R3: A stored period value of 0 acts as a period of 256.
- R4: The 4-bit output counter wraps from 15 to 0.
- R5: While `cnt_rd[i]` is high, `rd_data` shows timer i's counter. On the next clock edge that counter becomes 0, unless an increment lands on the same edge (see R9).
- R6: A pulse on `cnt_clr[i]` sets timer i's counter to 0 and leaves the other timers alone.
- R7: On the clock edge where `tmr_en[i]` is first seen high after being low, the prescaler, stage count and output counter of timer i all become 0.
- R8: While `tmr_en[i]` is low, timer i's output counter changes only through a read or a clear.
- R9: If a read or a clear coincides with an increment, the read returns the value from before the increment and the counter ends at 1.
- R10: After reset, all timers are disabled, all counters are 0 and every period register holds 0. An enabled timer that has never had a period written therefore behaves as having a period of 256.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Coprocessor clock (1.024 MHz in the target system) |
| rst_n | input | 1 | Active-low synchronous reset |
| tmr_en | input | 3 | Per-timer run enable (level) |
| per_wr | input | 3 | Per-timer period write strobe |
| per_data | input | 8 | Period value; 0 means 256 |
| cnt_rd | input | 3 | Per-timer read strobe; clears the counter at the edge |
| cnt_clr | input | 3 | Per-timer clear strobe |
| rd_data | output | 4 | Counter value of the timer whose read strobe is high |

## Verification
The hardest case to reach from the ports is a read that falls on exactly the same edge as an increment, because the counter advances only once every P×D clocks. The bench counts edges from a known enable edge, using timer 2 with period 1, and places the read strobe during the cycle just before the 32nd edge. It also has to see a counter's value without clearing it. To do that it raises the read strobe between clock edges, samples `rd_data` combinationally, and drops the strobe again before the next edge arrives.

// File: rtl/aud_tmr_pkg.sv
package aud_tmr_pkg;

  typedef logic [7:0] per_t;
  typedef logic [8:0] stage_t;
  typedef logic [3:0] cnt_t;

  // stored period to effective period; 0 stands for 256
  function automatic stage_t eff_period(input per_t p);
    return (p == 8'd0) ? 9'd256 : {1'b0, p};
  endfunction

  // true when one more step completes a period
  function automatic logic stage_done(input stage_t s, input stage_t per);
    return (s + 9'd1) >= per;
  endfunction

  // next output counter: a clear wins over the old value, an increment still lands
  function automatic cnt_t cnt_after(input cnt_t c, input logic clr, input logic inc);
    cnt_t base;
    base = clr ? 4'd0 : c;
    return inc ? base + 4'd1 : base;
  endfunction

endpackage

// File: rtl/aud_tmr_prescaler.sv
module aud_tmr_prescaler #(
  parameter int DIV = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic restart_i,
  output logic tick_o
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] div_q;

  assign tick_o = en_i && !restart_i && (div_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q <= '0;
    end else if (!en_i || restart_i) begin
      div_q <= '0;
    end else if (div_q == LAST) begin
      div_q <= '0;
    end else begin
      div_q <= div_q + 1'b1;
    end
  end

  // R1: the divider never runs past its last state
  p_div_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> (div_q == '0));

  // R7: a restart leaves the divider at zero
  p_div_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    restart_i |=> (div_q == '0));

endmodule

// File: rtl/aud_tmr_stage.sv
module aud_tmr_stage
  import aud_tmr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic restart_i,
  input  logic tick_i,
  input  logic per_wr_i,
  input  per_t per_data_i,
  output logic inc_o
);
  per_t   per_q;
  stage_t stage_q;
  stage_t per_eff;

  assign per_eff = eff_period(per_q);
  assign inc_o   = tick_i && stage_done(stage_q, per_eff);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      per_q <= '0;
    end else if (per_wr_i) begin
      per_q <= per_data_i;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage_q <= '0;
    end else if (restart_i) begin
      stage_q <= '0;
    end else if (tick_i) begin
      stage_q <= inc_o ? 9'd0 : stage_q + 9'd1;
    end
  end

  // R2: a completed period leaves the stage count at zero
  p_stage_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    inc_o |=> (stage_q == 9'd0));

  // R1: without a step the stage count holds
  p_stage_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !restart_i) |=> $stable(stage_q));

  // R7: an enable rise clears the stage count
  p_stage_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    restart_i |=> (stage_q == 9'd0));

endmodule

// File: rtl/aud_tmr_counter.sv
module aud_tmr_counter
  import aud_tmr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic restart_i,
  input  logic inc_i,
  input  logic rd_i,
  input  logic clr_i,
  output cnt_t cnt_o
);
  cnt_t cnt_q;
  logic zap;

  assign zap   = rd_i || clr_i;
  assign cnt_o = cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (restart_i) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_after(cnt_q, zap, inc_i);
    end
  end

  // R5: a read without an increment empties the counter
  p_rd_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && !inc_i) |=> (cnt_q == 4'd0));

  // R9: a read that meets an increment leaves exactly one count
  p_rd_tick_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && inc_i && !restart_i) |=> (cnt_q == 4'd1));

  // R4: fifteen plus one gives zero
  p_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_i && !zap && !restart_i && cnt_q == 4'd15) |=> (cnt_q == 4'd0));

  // R8: a disabled timer's counter holds unless read or cleared
  p_disabled_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_i && !zap) |=> $stable(cnt_q));

  // R7: an enable rise empties the counter
  p_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    restart_i |=> (cnt_q == 4'd0));

endmodule

// File: rtl/aud_interval_timers.sv
module aud_interval_timers
  import aud_tmr_pkg::*;
#(
  parameter int                  NUM_TMR   = 3,
  parameter int                  SLOW_DIV  = 128,
  parameter int                  FAST_DIV  = 16,
  parameter logic [NUM_TMR-1:0]  FAST_MASK = 3'b100
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_TMR-1:0] tmr_en,
  input  logic [NUM_TMR-1:0] per_wr,
  input  logic [7:0]         per_data,
  input  logic [NUM_TMR-1:0] cnt_rd,
  input  logic [NUM_TMR-1:0] cnt_clr,
  output logic [3:0]         rd_data
);
  logic [NUM_TMR-1:0] en_q;
  logic [NUM_TMR-1:0] restart;
  logic [NUM_TMR-1:0] step;
  logic [NUM_TMR-1:0] inc;
  cnt_t               cnt [NUM_TMR];

  assign restart = tmr_en & ~en_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q <= '0;
    end else begin
      en_q <= tmr_en;
    end
  end

  for (genvar i = 0; i < NUM_TMR; i++) begin : g_tmr
    localparam int DIV_I = FAST_MASK[i] ? FAST_DIV : SLOW_DIV;

    aud_tmr_prescaler #(.DIV(DIV_I)) u_pre (
      .clk       (clk),
      .rst_n     (rst_n),
      .en_i      (tmr_en[i]),
      .restart_i (restart[i]),
      .tick_o    (step[i])
    );

    aud_tmr_stage u_stage (
      .clk        (clk),
      .rst_n      (rst_n),
      .restart_i  (restart[i]),
      .tick_i     (step[i]),
      .per_wr_i   (per_wr[i]),
      .per_data_i (per_data),
      .inc_o      (inc[i])
    );

    aud_tmr_counter u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .en_i      (tmr_en[i]),
      .restart_i (restart[i]),
      .inc_i     (inc[i]),
      .rd_i      (cnt_rd[i]),
      .clr_i     (cnt_clr[i]),
      .cnt_o     (cnt[i])
    );
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_TMR; i++) begin
      if (cnt_rd[i]) rd_data = rd_data | cnt[i];
    end
  end

  // R8: a disabled timer never produces a prescaled step
  p_no_step_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((~tmr_en) & step) == '0);

  // R2: counter increments arise only from prescaled steps
  p_inc_needs_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (inc & ~step) == '0);

endmodule

// File: tb/aud_interval_timers_tb.sv
`timescale 1ns/1ps
module aud_interval_timers_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] tmr_en = '0;
  logic [2:0] per_wr = '0;
  logic [7:0] per_data = '0;
  logic [2:0] cnt_rd = '0;
  logic [2:0] cnt_clr = '0;
  logic [3:0] rd_data;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  aud_interval_timers u_dut (
    .clk(clk), .rst_n(rst_n), .tmr_en(tmr_en), .per_wr(per_wr),
    .per_data(per_data), .cnt_rd(cnt_rd), .cnt_clr(cnt_clr), .rd_data(rd_data)
  );

  // vector: timer[29:28] period[27:20] edges[19:4] expected[3:0]
  localparam int NV = 10;
  localparam logic [29:0] VEC [NV] = '{
    {2'd2, 8'd3, 16'd47,   4'd0},  // R1 one edge short
    {2'd2, 8'd3, 16'd48,   4'd1},  // R2 first increment
    {2'd2, 8'd3, 16'd96,   4'd2},  // R2 second increment
    {2'd0, 8'd2, 16'd255,  4'd0},  // R1 slow timer short
    {2'd0, 8'd2, 16'd256,  4'd1},  // R1 slow timer
    {2'd1, 8'd1, 16'd640,  4'd5},  // R1 timer 1 five steps
    {2'd2, 8'd0, 16'd4095, 4'd0},  // R3 period 256 short
    {2'd2, 8'd0, 16'd4096, 4'd1},  // R3 period 256
    {2'd2, 8'd1, 16'd256,  4'd0},  // R4 sixteen wraps to zero
    {2'd2, 8'd1, 16'd272,  4'd1}   // R4 seventeen
  };

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // look at a counter without clearing it: strobe up and down between edges
  task automatic peek(input int t, output int v);
    cnt_rd = 3'(1 << t);
    #1;
    v = rd_data;
    cnt_rd = '0;
  endtask

  // restart timer t with period p; returns at the negedge before the enable edge
  task automatic start(input int t, input int p);
    @(negedge clk);
    tmr_en[t] = 1'b0;
    per_wr = 3'(1 << t);
    per_data = 8'(p);
    @(negedge clk);
    per_wr = '0;
    tmr_en[t] = 1'b1;
  endtask

  task automatic edges_then_peek(input int n, input int t, output int v);
    repeat (n + 1) @(posedge clk);
    @(negedge clk);
    peek(t, v);
  endtask

  initial begin
    #(10 * 150000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int v;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R10 reset state
    for (int t = 0; t < 3; t++) begin
      @(negedge clk);
      peek(t, v);
      check("R10 counter zero", v, 0);
    end
    // R10 period register resets to 0, so 256 steps per count
    @(negedge clk);
    tmr_en[2] = 1'b1;
    edges_then_peek(4095, 2, v);
    check("R10 default period short", v, 0);
    edges_then_peek(0, 2, v);
    check("R10 default period", v, 1);
    tmr_en = '0;

    // vector table
    for (int k = 0; k < NV; k++) begin
      start(int'(VEC[k][29:28]), int'(VEC[k][27:20]));
      edges_then_peek(int'(VEC[k][19:4]), int'(VEC[k][29:28]), v);
      check($sformatf("R1/R2/R3/R4 vector %0d", k), v, int'(VEC[k][3:0]));
      tmr_en = '0;
    end

    // R5 read returns value and clears
    start(2, 0);
    edges_then_peek(4096, 2, v);
    @(negedge clk);
    cnt_rd = 3'b100;
    #1;
    check("R5 read value", rd_data, 1);
    @(negedge clk);
    cnt_rd = '0;
    peek(2, v);
    check("R5 cleared after read", v, 0);
    tmr_en = '0;

    // R6 clear strobe, other timer untouched
    start(1, 1);
    tmr_en[2] = 1'b1;
    @(negedge clk);
    tmr_en[2] = 1'b0;
    @(negedge clk);
    tmr_en[2] = 1'b1;          // timer 2 restarted one cycle after timer 1
    edges_then_peek(384, 1, v);
    check("R6 timer1 before clear", v, 3);
    @(negedge clk);
    cnt_clr = 3'b010;
    @(negedge clk);
    cnt_clr = '0;
    peek(1, v);
    check("R6 cleared", v, 0);
    peek(2, v);
    check("R6 neighbour kept", v, 0);  // period 256 timer, no count yet
    tmr_en = '0;

    // R8 disabled timer holds
    start(2, 1);
    edges_then_peek(48, 2, v);
    check("R8 running count", v, 3);
    tmr_en[2] = 1'b0;
    repeat (100) @(posedge clk);
    @(negedge clk);
    peek(2, v);
    check("R8 held while disabled", v, 3);

    // R7 enable rise restarts everything
    tmr_en[2] = 1'b1;
    edges_then_peek(0, 2, v);
    check("R7 counter cleared on enable", v, 0);
    edges_then_peek(14, 2, v);
    check("R7 prescaler restarted short", v, 0);
    edges_then_peek(0, 2, v);
    check("R7 prescaler restarted", v, 1);
    tmr_en = '0;

    // R9 read coincides with increment on edge 32
    start(2, 1);
    repeat (32) @(posedge clk);
    @(negedge clk);
    cnt_rd = 3'b100;
    #1;
    check("R9 read gives pre-increment value", rd_data, 1);
    @(negedge clk);
    cnt_rd = '0;
    peek(2, v);
    check("R9 counter ends at one", v, 1);
    tmr_en = '0;

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule